// File: doc/BRIEF.md
# Cross-Clock Timer Register Update Bridge

This block sits between a register bus running on a fast bus clock and a timer core that may run from its own slow clock. It holds five timer registers: counter value, compare A, compare B, control A and control B. It also holds a status register that selects the clock source, enables an external clock input, and reports one update-busy flag per timer register.

In synchronous mode every write lands at once in a bus-domain register that feeds the timer directly, and no busy flag is raised. In asynchronous mode a write is first captured in a bus-domain holding register. A toggle request then crosses into the slow domain through two slow-clock flops, and the slow domain loads its copy from the holding register. An acknowledge toggle returns through two bus-clock flops and clears the busy flag.

A second write to a register whose flag is still set is refused and flagged on an error pulse, so the transfer in flight is never corrupted. Reads of timer registers in asynchronous mode return the slow-domain values through two-flop synchronisers.

Top module: `tmr_async_regbridge`

## Requirements
- R1: After reset the status register reads 0x00, all five timer outputs are 0x00, `wr_collide` is low and `xtal_en` is high.
- R2: The status register sits at address 0xB6. Bit 7 reads 0. Bit 6 is the external clock enable and bit 5 the asynchronous mode select; both are written by bus writes. Bits 4..0 are busy flags for counter (bit 4), compare A (bit 3), compare B (bit 2), control A (bit 1) and control B (bit 0), and writes to these bits have no effect.
- R3: With bit 5 clear, a write to control A (0xB0), control B (0xB1), counter (0xB2), compare A (0xB3) or compare B (0xB4) is visible on the matching timer output and on a read of that address one bus cycle later, and no busy flag is raised.
- R4: With bit 5 set, a write to a timer register sets that register's busy flag in the cycle after the write edge and leaves the other flags unchanged.
- R5: A busy flag stays set for at least two slow-clock periods plus one bus period after the write edge, and clears within three slow-clock periods plus three bus periods.
- R6: Once a busy flag has cleared, the matching timer output and a bus read of that register both return the value that was written.
- R7: A write to a register whose busy flag is set is dropped. `wr_collide` is high for exactly the one cycle after that write edge, and the value that was already in flight is the one delivered.
- R8: `xtal_en` is always the inverse of the external clock enable bit.
- R9: Writes to different timer registers on nearby cycles each raise their own flag and each deliver their own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register bus clock |
| rst_bus_n | input | 1 | Synchronous active-low reset, bus domain |
| clk_tmr | input | 1 | Slow timer clock |
| rst_tmr_n | input | 1 | Synchronous active-low reset, timer domain |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Register byte address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| wr_collide | output | 1 | One-cycle pulse: write refused because its register was busy |
| ext_clk_en | output | 1 | External clock input enable (status bit 6) |
| xtal_en | output | 1 | Crystal oscillator enable, high while bit 6 is clear |
| async_sel | output | 1 | Asynchronous mode select (status bit 5) |
| tmr_count | output | 8 | Counter value seen by the timer core |
| tmr_cmp_a | output | 8 | Compare A value seen by the timer core |
| tmr_cmp_b | output | 8 | Compare B value seen by the timer core |
| tmr_ctl_a | output | 8 | Control A value seen by the timer core |
| tmr_ctl_b | output | 8 | Control B value seen by the timer core |

## Verification
The assertions assume three things about the inputs:
- The mode select bit does not change while any busy flag is set.
- The external clock enable is programmed before asynchronous mode is selected.
- Neither clock stops while a transfer is pending.

Under these conditions the holding register stays frozen for the whole of a handshake, and the slow domain always loads a stable value. The stimulus polls the status register until every flag is clear before it changes mode. It sets bit 6 in its own write ahead of the write that sets bit 5. Its only writes to a busy register fall well inside the window where the flag is certain to be set, so the collision result never depends on the exact clock phase.

// File: rtl/tmr_bridge_pkg.sv
`timescale 1ns/1ps
package tmr_bridge_pkg;
    localparam int NUM_REG      = 5;
    // lane index equals the busy-flag bit position in the status register
    localparam int LN_CTL_B     = 0;
    localparam int LN_CTL_A     = 1;
    localparam int LN_CMP_B     = 2;
    localparam int LN_CMP_A     = 3;
    localparam int LN_COUNT     = 4;
    localparam int ST_ASYNC_BIT = 5;
    localparam int ST_EXT_BIT   = 6;
endpackage

// File: rtl/tmr_sync2.sv
`timescale 1ns/1ps
module tmr_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = d;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign q = sync_q.s2;
endmodule

// File: rtl/tmr_xfer_lane.sv
`timescale 1ns/1ps
module tmr_xfer_lane #(
    parameter int WIDTH = 8
) (
    input  logic             clk_bus,
    input  logic             rst_bus_n,
    input  logic             clk_tmr,
    input  logic             rst_tmr_n,
    input  logic             async_mode,
    input  logic             wr_hit,
    input  logic [WIDTH-1:0] wr_data,
    output logic             busy,
    output logic             collide,
    output logic [WIDTH-1:0] hold_val,
    output logic [WIDTH-1:0] tmr_val,
    output logic [WIDTH-1:0] rd_val
);
    typedef struct packed {
        logic [WIDTH-1:0] hold;
        logic             req;
    } bus_t;

    typedef struct packed {
        logic [WIDTH-1:0] val;
        logic             ack;
    } slw_t;

    bus_t bus_d, bus_q;
    slw_t slw_d, slw_q;
    logic ack_sync;
    logic req_sync;
    logic accept;

    // acknowledge back into the bus domain
    tmr_sync2 #(.WIDTH(1)) u_ack_sync (
        .clk(clk_bus), .rst_n(rst_bus_n), .d(slw_q.ack), .q(ack_sync)
    );
    // request into the slow domain
    tmr_sync2 #(.WIDTH(1)) u_req_sync (
        .clk(clk_tmr), .rst_n(rst_tmr_n), .d(bus_q.req), .q(req_sync)
    );
    // slow value back for reads
    tmr_sync2 #(.WIDTH(WIDTH)) u_val_sync (
        .clk(clk_bus), .rst_n(rst_bus_n), .d(slw_q.val), .q(rd_val)
    );

    assign busy    = bus_q.req ^ ack_sync;
    assign collide = wr_hit && async_mode && busy;
    assign accept  = wr_hit && !(async_mode && busy);

    always_comb begin
        bus_d = bus_q;
        if (accept) begin
            bus_d.hold = wr_data;
            if (async_mode) bus_d.req = ~bus_q.req;
        end
    end

    always_ff @(posedge clk_bus) begin
        if (!rst_bus_n) bus_q <= '0;
        else            bus_q <= bus_d;
    end

    always_comb begin
        slw_d = slw_q;
        if (req_sync != slw_q.ack) begin
            slw_d.val = bus_q.hold;
            slw_d.ack = req_sync;
        end
    end

    always_ff @(posedge clk_tmr) begin
        if (!rst_tmr_n) slw_q <= '0;
        else            slw_q <= slw_d;
    end

    assign hold_val = bus_q.hold;
    assign tmr_val  = slw_q.val;

    assert_busy_set_R4: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (wr_hit && async_mode && !busy) |=> busy);

    assert_hold_frozen_R7: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (async_mode && busy) |=> $stable(bus_q.hold));

    assert_sync_no_req_R3: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        !async_mode |=> $stable(bus_q.req));

    assert_load_value_R6: assert property (@(posedge clk_tmr) disable iff (!rst_tmr_n)
        (req_sync != slw_q.ack) |=> (slw_q.val == $past(bus_q.hold)));
endmodule

// File: rtl/tmr_async_regbridge.sv
`timescale 1ns/1ps
module tmr_async_regbridge
    import tmr_bridge_pkg::*;
#(
    parameter int                  DATA_W      = 8,
    parameter int                  ADDR_W      = 8,
    parameter logic [ADDR_W-1:0]   ADDR_STATUS = 8'hB6,
    parameter logic [ADDR_W-1:0]   ADDR_CTL_A  = 8'hB0,
    parameter logic [ADDR_W-1:0]   ADDR_CTL_B  = 8'hB1,
    parameter logic [ADDR_W-1:0]   ADDR_COUNT  = 8'hB2,
    parameter logic [ADDR_W-1:0]   ADDR_CMP_A  = 8'hB3,
    parameter logic [ADDR_W-1:0]   ADDR_CMP_B  = 8'hB4
) (
    input  logic              clk_bus,
    input  logic              rst_bus_n,
    input  logic              clk_tmr,
    input  logic              rst_tmr_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wr_collide,
    output logic              ext_clk_en,
    output logic              xtal_en,
    output logic              async_sel,
    output logic [DATA_W-1:0] tmr_count,
    output logic [DATA_W-1:0] tmr_cmp_a,
    output logic [DATA_W-1:0] tmr_cmp_b,
    output logic [DATA_W-1:0] tmr_ctl_a,
    output logic [DATA_W-1:0] tmr_ctl_b
);
    typedef struct packed {
        logic ext;
        logic async_m;
        logic collide;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_REG-1:0] hit_vec;
    logic [NUM_REG-1:0] busy_vec;
    logic [NUM_REG-1:0] col_vec;
    logic [DATA_W-1:0]  lane_hold [NUM_REG];
    logic [DATA_W-1:0]  lane_tmr  [NUM_REG];
    logic [DATA_W-1:0]  lane_rd   [NUM_REG];
    logic [DATA_W-1:0]  lane_out  [NUM_REG];
    logic [DATA_W-1:0]  rdata_c;

    function automatic logic [ADDR_W-1:0] lane_addr(input int idx);
        case (idx)
            LN_COUNT: return ADDR_COUNT;
            LN_CMP_A: return ADDR_CMP_A;
            LN_CMP_B: return ADDR_CMP_B;
            LN_CTL_A: return ADDR_CTL_A;
            default:  return ADDR_CTL_B;
        endcase
    endfunction

    for (genvar g = 0; g < NUM_REG; g++) begin : g_lane
        assign hit_vec[g] = bus_wr && (bus_addr == lane_addr(g));

        tmr_xfer_lane #(.WIDTH(DATA_W)) u_lane (
            .clk_bus   (clk_bus),
            .rst_bus_n (rst_bus_n),
            .clk_tmr   (clk_tmr),
            .rst_tmr_n (rst_tmr_n),
            .async_mode(st_q.async_m),
            .wr_hit    (hit_vec[g]),
            .wr_data   (bus_wdata),
            .busy      (busy_vec[g]),
            .collide   (col_vec[g]),
            .hold_val  (lane_hold[g]),
            .tmr_val   (lane_tmr[g]),
            .rd_val    (lane_rd[g])
        );

        assign lane_out[g] = st_q.async_m ? lane_tmr[g] : lane_hold[g];
    end

    always_comb begin
        st_d         = st_q;
        st_d.collide = |col_vec;
        if (bus_wr && bus_addr == ADDR_STATUS) begin
            st_d.ext     = bus_wdata[ST_EXT_BIT];
            st_d.async_m = bus_wdata[ST_ASYNC_BIT];
        end

        rdata_c = '0;
        if (bus_addr == ADDR_STATUS) begin
            rdata_c[NUM_REG-1:0]  = busy_vec;
            rdata_c[ST_ASYNC_BIT] = st_q.async_m;
            rdata_c[ST_EXT_BIT]   = st_q.ext;
        end
        for (int i = 0; i < NUM_REG; i++) begin
            if (bus_addr == lane_addr(i))
                rdata_c = st_q.async_m ? lane_rd[i] : lane_hold[i];
        end
    end

    always_ff @(posedge clk_bus) begin
        if (!rst_bus_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign bus_rdata  = rdata_c;
    assign wr_collide = st_q.collide;
    assign ext_clk_en = st_q.ext;
    assign xtal_en    = ~st_q.ext;
    assign async_sel  = st_q.async_m;
    assign tmr_count  = lane_out[LN_COUNT];
    assign tmr_cmp_a  = lane_out[LN_CMP_A];
    assign tmr_cmp_b  = lane_out[LN_CMP_B];
    assign tmr_ctl_a  = lane_out[LN_CTL_A];
    assign tmr_ctl_b  = lane_out[LN_CTL_B];

    assert_collide_flag_R7: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (st_q.async_m && |(hit_vec & busy_vec)) |=> wr_collide);

    assert_collide_cause_R7: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        wr_collide |-> $past(bus_wr));

    assert_xtal_inverse_R8: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (bus_wr && bus_addr == ADDR_STATUS) |=> (xtal_en == !$past(bus_wdata[ST_EXT_BIT])));
endmodule

// File: tb/tb_tmr_async_regbridge.sv
`timescale 1ns/1ps
module tb_tmr_async_regbridge;
    localparam real TB = 5.0;
    localparam real TS = 83.0;
    localparam logic [7:0] A_ST = 8'hB6;

    logic clk_bus = 0, clk_tmr = 0, rst_bus_n = 0, rst_tmr_n = 0;
    logic bus_wr = 0;
    logic [7:0] bus_addr = A_ST, bus_wdata = 0, bus_rdata;
    logic wr_collide, ext_clk_en, xtal_en, async_sel;
    logic [7:0] tmr_count, tmr_cmp_a, tmr_cmp_b, tmr_ctl_a, tmr_ctl_b;

    tmr_async_regbridge dut (
        .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .clk_tmr(clk_tmr), .rst_tmr_n(rst_tmr_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wr_collide(wr_collide), .ext_clk_en(ext_clk_en), .xtal_en(xtal_en), .async_sel(async_sel),
        .tmr_count(tmr_count), .tmr_cmp_a(tmr_cmp_a), .tmr_cmp_b(tmr_cmp_b),
        .tmr_ctl_a(tmr_ctl_a), .tmr_ctl_b(tmr_ctl_b)
    );

    initial forever #(TB/2) clk_bus = ~clk_bus;
    initial begin #7; forever #(TS/2) clk_tmr = ~clk_tmr; end

    int vecs = 0, errs = 0;
    bit finished = 0, mon_on = 0;
    logic [7:0] exp_val [5];
    bit known [5], pend [5];
    realtime t_w [5];
    bit m_ext = 0, m_async = 0, exp_col = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $realtime);
        end
    endtask

    function automatic logic [7:0] addr_of(input int i);
        case (i)
            4: return 8'hB2;
            3: return 8'hB3;
            2: return 8'hB4;
            1: return 8'hB0;
            default: return 8'hB1;
        endcase
    endfunction

    function automatic logic [7:0] tmr_of(input int i);
        case (i)
            4: return tmr_count;
            3: return tmr_cmp_a;
            2: return tmr_cmp_b;
            1: return tmr_ctl_a;
            default: return tmr_ctl_b;
        endcase
    endfunction

    // behavioural reference, evaluated on every falling bus edge
    always @(negedge clk_bus) if (mon_on) begin
        check(wr_collide === exp_col, "R7 collide pulse", wr_collide, exp_col);
        check(xtal_en === !m_ext, "R8 xtal", xtal_en, !m_ext);
        check({ext_clk_en, async_sel} === {m_ext, m_async}, "R2 mode bits", {ext_clk_en, async_sel}, {m_ext, m_async});
        if (!bus_wr && bus_addr == A_ST) begin
            check(bus_rdata[7:5] === {1'b0, m_ext, m_async}, "R2 status upper", bus_rdata[7:5], {1'b0, m_ext, m_async});
            for (int i = 0; i < 5; i++) begin
                if (pend[i]) begin
                    realtime el;
                    el = $realtime - t_w[i];
                    if (el < 2*TS + TB)
                        check(bus_rdata[i] === 1'b1, "R4/R5 busy held", bus_rdata[i], 1);
                    else if (el > 3*TS + 3*TB) begin
                        check(bus_rdata[i] === 1'b0, "R5 busy cleared", bus_rdata[i], 0);
                        pend[i] = 0;
                    end else if (bus_rdata[i] === 1'b0)
                        pend[i] = 0;
                end else
                    check(bus_rdata[i] === 1'b0, "R3/R4 busy idle", bus_rdata[i], 0);
            end
        end
        exp_col = 0;
        if (bus_wr) begin
            if (bus_addr == A_ST) begin
                if (bus_wdata[5] != m_async) for (int i = 0; i < 5; i++) known[i] = 0;
                m_ext   = bus_wdata[6];
                m_async = bus_wdata[5];
            end else begin
                for (int i = 0; i < 5; i++) if (bus_addr == addr_of(i)) begin
                    if (m_async && pend[i]) exp_col = 1;
                    else begin
                        exp_val[i] = bus_wdata;
                        known[i]   = 1;
                        if (m_async) begin
                            pend[i] = 1;
                            t_w[i]  = $realtime + TB/2;
                        end
                    end
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk_bus); #1;
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk_bus); #1;
        bus_wr = 0; bus_addr = A_ST;
    endtask

    task automatic rd_chk(input int i, input string req);
        @(posedge clk_bus); #1;
        bus_addr = addr_of(i);
        @(negedge clk_bus);
        if (known[i]) begin
            check(bus_rdata === exp_val[i], req, bus_rdata, exp_val[i]);
            check(tmr_of(i) === exp_val[i], req, tmr_of(i), exp_val[i]);
        end
        @(posedge clk_bus); #1;
        bus_addr = A_ST;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk_bus);
        while (bus_rdata[4:0] !== 5'b0 && n < 400) begin
            @(negedge clk_bus);
            n++;
        end
        check(bus_rdata[4:0] === 5'b0, "R5 flags drain", bus_rdata[4:0], 0);
    endtask

    initial begin
        #(200000*TB);
        if (!finished) begin
            errs++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 5; i++) begin exp_val[i] = 0; known[i] = 1; pend[i] = 0; end
        #400;
        @(posedge clk_bus); #1; rst_bus_n = 1; rst_tmr_n = 1;
        @(negedge clk_bus);
        // R1 reset state
        check(bus_rdata === 8'h00, "R1 status", bus_rdata, 0);
        check(wr_collide === 1'b0, "R1 collide", wr_collide, 0);
        check(xtal_en === 1'b1, "R1 xtal", xtal_en, 1);
        for (int i = 0; i < 5; i++) check(tmr_of(i) === 8'h00, "R1 timer out", tmr_of(i), 0);
        mon_on = 1;

        // R3 synchronous writes
        for (int i = 0; i < 5; i++) wr(addr_of(i), 8'h10 + 8'(i));
        for (int i = 0; i < 5; i++) rd_chk(i, "R3 sync value");

        // R2: low status bits ignored, enable external clock before async
        wr(A_ST, 8'h5F);
        wr(A_ST, 8'h60);

        // R4/R5/R6 single async write
        wr(8'hB2, 8'hA5);
        wait_idle();
        rd_chk(4, "R6 count value");

        // R9 five registers back to back
        for (int i = 0; i < 5; i++) wr(addr_of(i), 8'hC0 + 8'(i * 3));
        wait_idle();
        for (int i = 0; i < 5; i++) rd_chk(i, "R9 lane value");

        // R7 write while busy is refused
        wr(8'hB3, 8'h11);
        wr(8'hB3, 8'h22);
        wait_idle();
        rd_chk(3, "R7 first value kept");
        wr(8'hB3, 8'h33);
        wait_idle();
        rd_chk(3, "R6 rewrite value");

        // back to synchronous mode
        wr(A_ST, 8'h40);
        wr(8'hB1, 8'h77);
        rd_chk(0, "R3 sync after async");
        wr(A_ST, 8'h00);
        repeat (3) @(negedge clk_bus);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule